// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block sits beside the command decoder of a serial nonvolatile memory. It keeps the protection-related bits of the memory's status byte and rules on every write request the decoder hands it. These bits are the lock bit, the two protect-select bits and the write-enable latch. The decoder presents one-cycle strobes for setting and clearing the write-enable latch, for a status-byte write and for a data-array write. With them it presents the new status byte and the target address of a data write. The block answers with a one-cycle permit pulse for each write it accepts. It also presents the assembled status byte for read-out, and a flag that is high while hardware-protected mode is in force.

Two protection modes exist. In software-protected mode, the protect-select bits fence off part of the array, and the status byte can be rewritten once the write-enable latch is set. Hardware-protected mode applies when the lock bit is 1 and the external write-protect pin is low. In that mode the status byte is frozen, including the fence itself. The pin is asynchronous, so it passes through a reset-to-low synchronizer, and a floating pin is treated as low. While the memory core reports busy, every strobe is ignored.

Top module: `wpc_guard`

## Requirements
- R1: After synchronous reset, the status byte reads 0x00 (core idle), the permit output is low and the hardware-lock flag is low.
- R2: Status byte fields are lock at bit 7, protect-select at bits 3:2 (bit 3 high), write-enable latch at bit 1, and busy at bit 0. Bits 6, 5 and 4 read 0. Bit 0 follows the core busy input in the same cycle.
- R3: A set strobe raises the write-enable latch on the next cycle and a clear strobe drops it. When several strobes arrive together, only the highest one acts, in the order clear, set, status write, data write.
- R4: With the lock bit at 0, a status write loads bit 7 into the lock bit and bits 3:2 into protect-select whenever the latch is set, at any pin level. Without the latch, it changes nothing.
- R5: With the lock bit at 1 and the pin high, a status write is accepted only when the latch is set.
- R6: With the lock bit at 1 and the pin low, the hardware-lock flag is high and every status write is ignored, even with the latch set.
- R7: Hardware-protected mode is entered by writing the lock bit while the pin is low, or by pulling the pin low while the lock bit is 1. Only a high pin ends it. Pin changes take effect after SYNC_STAGES clock edges.
- R8: Protect-select 00, 01, 10 and 11 guard nothing, the top quarter (address bits [ADDR_W-1:ADDR_W-2] both 1), the top half (MSB 1) and the whole array. A data write is permitted only outside the guarded area and only with the latch set, in either mode.
- R9: Every status or data write handled while the core is idle clears the write-enable latch, whether it was accepted or rejected.
- R10: While core busy is high, all strobes are ignored: bits 7:1 of the status byte keep their value and no permit is given.
- R11: The permit output is high for exactly the one cycle after an accepted status or data write, and is low otherwise.
- R12: An undriven write-protect pin is read as low, so a set lock bit with a floating pin enters hardware-protected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we_set | input | 1 | Strobe: set write-enable latch |
| cmd_we_clr | input | 1 | Strobe: clear write-enable latch |
| cmd_stat_wr | input | 1 | Strobe: write status byte |
| cmd_data_wr | input | 1 | Strobe: write to data array |
| wr_addr | input | ADDR_W | Target address of a data write |
| stat_wdata | input | 8 | New status byte for a status write |
| wp_pin | input | 1 | External write-protect pin, asynchronous, low = protect |
| core_busy | input | 1 | Memory core write in progress |
| status_rd | output | 8 | Assembled status byte |
| wr_permit | output | 1 | One-cycle pulse for an accepted write |
| hw_lock | output | 1 | Hardware-protected mode active |

## Verification
On every cycle, the bound checker enforces the latch rules: set, clear, strobe priority and the clear after any handled write. It also checks that the upper status bits stay frozen while busy, under hardware lock, or when a status write lacks the latch, and that every permit pulse traces back to an idle-core write with the latch set. Other behaviours come only from the directed scenarios, because they depend on a sequence of steps. These are the two entry orders into hardware-protected mode and the exit through the pin, the floating-pin case, the address fence for each protect-select code at its exact boundary addresses, and the bit layout of the read-out byte.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;

    localparam int STAT_W   = 8;
    localparam int B_LOCK   = 7;
    localparam int B_PS_HI  = 3;
    localparam int B_PS_LO  = 2;
    localparam int B_WEL    = 1;
    localparam int B_BUSY   = 0;

    // Decoded operation after priority resolution
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WE_CLR  = 3'd1,
        OP_WE_SET  = 3'd2,
        OP_STAT_WR = 3'd3,
        OP_DATA_WR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        PS_NONE    = 2'b00,
        PS_QUARTER = 2'b01,
        PS_HALF    = 2'b10,
        PS_ALL     = 2'b11
    } prot_sel_e;

    typedef struct packed {
        logic      lock;
        prot_sel_e prot_sel;
        logic      we_latch;
    } guard_state_t;

    localparam guard_state_t STATE_RST = '{lock: 1'b0, prot_sel: PS_NONE, we_latch: 1'b0};

    // Clear beats set beats status write beats data write
    function automatic op_e pick_op(input logic we_clr, input logic we_set,
                                    input logic stat_wr, input logic data_wr);
        if (we_clr)       return OP_WE_CLR;
        else if (we_set)  return OP_WE_SET;
        else if (stat_wr) return OP_STAT_WR;
        else if (data_wr) return OP_DATA_WR;
        else              return OP_NONE;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input guard_state_t s, input logic busy);
        logic [STAT_W-1:0] b;
        b           = '0;
        b[B_LOCK]   = s.lock;
        b[B_PS_HI]  = s.prot_sel[1];
        b[B_PS_LO]  = s.prot_sel[0];
        b[B_WEL]    = s.we_latch;
        b[B_BUSY]   = busy;
        return b;
    endfunction

    // Only the writable fields are taken; the latch is dropped by the write itself
    function automatic guard_state_t apply_stat(input logic [STAT_W-1:0] d);
        guard_state_t s;
        s.lock     = d[B_LOCK];
        s.prot_sel = prot_sel_e'({d[B_PS_HI], d[B_PS_LO]});
        s.we_latch = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/wpc_pin_sync.sv
`timescale 1ns/1ps
module wpc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    // Reset to low: a pin of unknown state is treated as protecting
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/wpc_region.sv
`timescale 1ns/1ps
module wpc_region
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  prot_sel_e          prot_sel,
    input  logic [ADDR_W-1:0]  addr,
    output logic               in_guard
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (prot_sel)
            PS_NONE:    in_guard = 1'b0;
            PS_QUARTER: in_guard = addr[TOP] & addr[TOP-1];
            PS_HALF:    in_guard = addr[TOP];
            PS_ALL:     in_guard = 1'b1;
            default:    in_guard = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpc_core.sv
`timescale 1ns/1ps
module wpc_core
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              in_guard,
    input  logic              pin_lvl,
    input  logic              busy,
    output guard_state_t      state,
    output logic              permit,
    output logic              hpm
);
    guard_state_t st_q, st_d;
    logic         grant_d, permit_q;

    assign hpm = st_q.lock & ~pin_lvl;

    always_comb begin
        st_d    = st_q;
        grant_d = 1'b0;
        if (!busy) begin
            unique case (op)
                OP_WE_CLR: st_d.we_latch = 1'b0;
                OP_WE_SET: st_d.we_latch = 1'b1;
                OP_STAT_WR: begin
                    st_d.we_latch = 1'b0;
                    if (st_q.we_latch && !hpm) begin
                        st_d    = apply_stat(stat_wdata);
                        grant_d = 1'b1;
                    end
                end
                OP_DATA_WR: begin
                    st_d.we_latch = 1'b0;
                    if (st_q.we_latch && !in_guard) grant_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= STATE_RST;
            permit_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            permit_q <= grant_d;
        end
    end

    assign state  = st_q;
    assign permit = permit_q;
endmodule

// File: rtl/wpc_guard.sv
`timescale 1ns/1ps
module wpc_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we_set,
    input  logic              cmd_we_clr,
    input  logic              cmd_stat_wr,
    input  logic              cmd_data_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        stat_wdata,
    input  logic              wp_pin,
    input  logic              core_busy,
    output logic [7:0]        status_rd,
    output logic              wr_permit,
    output logic              hw_lock
);
    op_e          op;
    logic         pin_lvl;
    logic         in_guard;
    guard_state_t state;

    assign op = pick_op(cmd_we_clr, cmd_we_set, cmd_stat_wr, cmd_data_wr);

    wpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (wp_pin),
        .pin_sync  (pin_lvl)
    );

    wpc_region #(.ADDR_W(ADDR_W)) u_region (
        .prot_sel (state.prot_sel),
        .addr     (wr_addr),
        .in_guard (in_guard)
    );

    wpc_core u_core (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .stat_wdata (stat_wdata),
        .in_guard   (in_guard),
        .pin_lvl    (pin_lvl),
        .busy       (core_busy),
        .state      (state),
        .permit     (wr_permit),
        .hpm        (hw_lock)
    );

    assign status_rd = pack_status(state, core_busy);
endmodule

// File: rtl/wpc_guard_chk.sv
`timescale 1ns/1ps
module wpc_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_we_set,
    input logic       cmd_we_clr,
    input logic       cmd_stat_wr,
    input logic       cmd_data_wr,
    input logic       core_busy,
    input logic [7:0] status_rd,
    input logic       wr_permit,
    input logic       hw_lock
);
    logic any_cmd;
    assign any_cmd = cmd_we_set | cmd_we_clr | cmd_stat_wr | cmd_data_wr;

    assert_set_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (!core_busy && cmd_we_set && !cmd_we_clr) |=> status_rd[1]);

    assert_clear_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (!core_busy && cmd_we_clr) |=> !status_rd[1]);

    assert_no_latch_no_change_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_stat_wr && !status_rd[1]) |=> $stable(status_rd[7:2]));

    assert_hw_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_stat_wr && hw_lock) |=> $stable(status_rd[7:2]));

    assert_latch_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (!core_busy && (cmd_stat_wr || cmd_data_wr) && !cmd_we_set && !cmd_we_clr)
        |=> !status_rd[1]);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (core_busy && any_cmd) |=> ($stable(status_rd[7:1]) && !wr_permit));

    assert_permit_cause_R11: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> ($past(cmd_stat_wr || cmd_data_wr) && !$past(core_busy)
                       && $past(status_rd[1])));
endmodule

bind wpc_guard wpc_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_we_set  (cmd_we_set),
    .cmd_we_clr  (cmd_we_clr),
    .cmd_stat_wr (cmd_stat_wr),
    .cmd_data_wr (cmd_data_wr),
    .core_busy   (core_busy),
    .status_rd   (status_rd),
    .wr_permit   (wr_permit),
    .hw_lock     (hw_lock)
);

// File: tb/sim_wpc_guard.sv
`timescale 1ns/1ps
module sim_wpc_guard;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we_set = 0, we_clr = 0, st_wr = 0, d_wr = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    sdata = '0;
    logic          busy = 0;
    logic          wp_oe = 1'b1, wp_val = 1'b1;
    wire           wp_net;
    logic [7:0]    status;
    logic          permit, lock;
    int            n_cmp = 0, n_bad = 0;
    bit            done = 0;

    pulldown (wp_net);
    assign wp_net = wp_oe ? wp_val : 1'bz;

    always #2.5 clk = ~clk;

    wpc_guard #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .cmd_we_set(we_set), .cmd_we_clr(we_clr),
        .cmd_stat_wr(st_wr), .cmd_data_wr(d_wr), .wr_addr(addr),
        .stat_wdata(sdata), .wp_pin(wp_net), .core_busy(busy),
        .status_rd(status), .wr_permit(permit), .hw_lock(lock)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present strobes for one clock; return just after the following negedge
    task automatic op(input logic c, input logic s, input logic w, input logic d,
                      input logic [7:0] v, input logic [AW-1:0] a);
        we_clr = c; we_set = s; st_wr = w; d_wr = d; sdata = v; addr = a;
        @(negedge clk);
        we_clr = 0; we_set = 0; st_wr = 0; d_wr = 0;
    endtask

    task automatic pin(input logic oe, input logic v);
        wp_oe = oe; wp_val = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_stat(input logic [7:0] v);
        return {v[7], 3'b000, v[3:2], 2'b00};
    endfunction

    function automatic logic guarded(input logic [1:0] ps, input logic [AW-1:0] a);
        case (ps)
            2'b00:   return 1'b0;
            2'b01:   return a >= 10'd768;
            2'b10:   return a >= 10'd512;
            default: return 1'b1;
        endcase
    endfunction

    task automatic load(input logic [7:0] v);
        pin(1, 1);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, v, 0);
    endtask

    task automatic t_reset;
        chk("R1", "status", status, 8'h00);
        chk("R1", "permit", {7'd0, permit}, 8'h00);
        chk("R1", "lock", {7'd0, lock}, 8'h00);
    endtask

    task automatic t_layout;
        load(8'hFF);
        chk("R2", "status after FF", status, 8'h8C);
        busy = 1; #1;
        chk("R2", "busy bit", status, 8'h8D);
        busy = 0; #1;
        load(8'h00);
        chk("R2", "cleared", status, 8'h00);
    endtask

    task automatic t_latch;
        op(0, 1, 0, 0, 0, 0);
        chk("R3", "latch set", status, 8'h02);
        op(1, 0, 0, 0, 0, 0);
        chk("R3", "latch clear", status, 8'h00);
        op(1, 1, 0, 0, 0, 0);
        chk("R3", "clear beats set", status, 8'h00);
        op(0, 1, 1, 0, 8'h0C, 0);
        chk("R3", "set beats status write", status, 8'h02);
        chk("R3", "no permit", {7'd0, permit}, 8'h00);
        op(1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_soft;
        pin(1, 0);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h0C, 0);
        chk("R4", "write with pin low", status, 8'h0C);
        chk("R11", "permit pulse", {7'd0, permit}, 8'h01);
        @(negedge clk);
        chk("R11", "permit one cycle", {7'd0, permit}, 8'h00);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R4", "no latch ignored", status, 8'h0C);
        chk("R4", "no latch no permit", {7'd0, permit}, 8'h00);
        pin(1, 1);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h84, 0);
        chk("R5", "lock set pin high", status, 8'h84);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R5", "no latch ignored", status, 8'h84);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h88, 0);
        chk("R5", "rewrite while locked, pin high", status, 8'h88);
        chk("R9", "latch dropped", {7'd0, status[1]}, 8'h00);
    endtask

    task automatic t_hard;
        // lock already 1 (status 0x88); pull pin low second
        pin(1, 0);
        chk("R7", "enter by pin", {7'd0, lock}, 8'h01);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R6", "write ignored in hpm", status, 8'h88);
        chk("R6", "no permit", {7'd0, permit}, 8'h00);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 0, 1, 0, 10'd100);
        chk("R8", "unguarded data write in hpm", {7'd0, permit}, 8'h01);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 0, 1, 0, 10'd600);
        chk("R8", "guarded data write in hpm", {7'd0, permit}, 8'h00);
        chk("R9", "latch dropped on reject", status, 8'h88);
        pin(1, 1);
        chk("R7", "leave by pin", {7'd0, lock}, 8'h00);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R7", "writable after exit", status, 8'h00);
        // other order: pin low first, then set lock
        pin(1, 0);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h80, 0);
        chk("R7", "lock written with pin low", status, 8'h80);
        chk("R7", "enter by lock", {7'd0, lock}, 8'h01);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R6", "frozen", status, 8'h80);
        pin(1, 1);
        load(8'h00);
    endtask

    task automatic t_float;
        load(8'h80);
        pin(0, 0);
        chk("R12", "floating pin locks", {7'd0, lock}, 8'h01);
        op(0, 1, 0, 0, 0, 0);
        op(0, 0, 1, 0, 8'h00, 0);
        chk("R12", "write ignored", status, 8'h80);
        load(8'h00);
        chk("R12", "restored", status, 8'h00);
    endtask

    task automatic t_region;
        logic [AW-1:0] pts [6];
        pts = '{10'd0, 10'd511, 10'd512, 10'd767, 10'd768, 10'd1023};
        for (int ps = 0; ps < 4; ps++) begin
            load({4'b0000, ps[1:0], 2'b00});
            for (int i = 0; i < 6; i++) begin
                op(0, 1, 0, 0, 0, 0);
                op(0, 0, 0, 1, 0, pts[i]);
                chk("R8", $sformatf("ps %0d addr %0d", ps, pts[i]),
                    {7'd0, permit}, {7'd0, ~guarded(ps[1:0], pts[i])});
            end
            op(0, 0, 0, 1, 0, 10'd0);
            chk("R8", "no latch no data write", {7'd0, permit}, 8'h00);
        end
        load(8'h00);
    endtask

    task automatic t_busy;
        op(0, 1, 0, 0, 0, 0);
        busy = 1;
        op(0, 0, 1, 0, 8'h8C, 0);
        chk("R10", "status write ignored", status, 8'h03);
        chk("R10", "no permit", {7'd0, permit}, 8'h00);
        op(1, 0, 0, 0, 0, 0);
        chk("R10", "clear ignored", status, 8'h03);
        op(0, 0, 0, 1, 0, 0);
        chk("R10", "data write ignored", {7'd0, permit}, 8'h00);
        busy = 0;
        op(0, 0, 0, 1, 0, 0);
        chk("R10", "latch survived busy", {7'd0, permit}, 8'h01);
        chk("R9", "latch dropped", status, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset; t_layout; t_latch; t_soft; t_hard; t_float; t_region; t_busy;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule